// File: doc/BRIEF.md
# UART Interrupt Priority and Identification

This block gathers the interrupt conditions of a UART into a single active-high interrupt request and a 4-bit identification code. The receiver, transmitter, FIFOs and the character time-out counter sit outside it and deliver their results as status inputs. The host writes a 4-bit enable value. It can read back that value and a snapshot of the identification code. Access strobes to the other UART registers clear the matching pending sources.

Line errors, modem changes and character time-outs are held in sticky pending bits until their clearing access arrives. Received-data-available follows its status level directly. Transmit-holding-empty is captured as an event: either the empty flag goes from 0 to 1, or its enable is switched on while the holding register is already empty. Only the highest-priority source that is both pending and enabled is reported. There is no data stream through the block, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `uirq_ident`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `en_rdata` is 0x00, `irq` is 0, and both `id_now` and `id_rdata` read 4'b0001.
- R2: A cycle with `en_wr` high loads `en_wdata[3:0]` into the enable register. `en_rdata[3:0]` returns that value from the next cycle, and `en_rdata[7:4]` always reads 0. Bit 0 enables received-data and time-out, bit 1 enables transmit-empty, bit 2 enables line status, and bit 3 enables modem status.
- R3: `id_now` reports the pending, enabled source of highest priority, using these codes: line status 4'b0110, received data 4'b0100, time-out 4'b1100, transmit empty 4'b0010, modem 4'b0000, none 4'b0001. The order, highest first, is line status, received data, time-out, transmit empty, modem.
- R4: A time-out is reported only while `fifo_mode` is 1. While `fifo_mode` is 0, `id_now[3]` is 0.
- R5: A disabled source is never reported and never raises `irq`. Its pending bit still sets, so enabling it later reports it.
- R6: A cycle with `line_err` high sets line-status pending from the next cycle. `lsr_rd` clears it, and a set in the same cycle wins over the clear.
- R7: A cycle with `modem_chg` high sets modem pending. `msr_rd` clears it, and a set in the same cycle wins.
- R8: Received data is pending exactly while `rx_avail` is 1. A cycle with `char_timeout` high sets time-out pending, `rbr_rd` clears it, and a set in the same cycle wins.
- R9: Transmit-empty pending sets on a 0-to-1 change of `tx_empty`, or on an enable write that turns bit 1 from 0 to 1 while `tx_empty` is 1.
- R10: Transmit-empty pending clears on `thr_wr`, or on `id_rd` in a cycle where `id_now` is 4'b0010. An `id_rd` while another code is shown leaves it pending. A set event wins over a clear in the same cycle.
- R11: On `id_rd`, `id_rdata` captures that cycle's `id_now` and holds it until the next `id_rd`.
- R12: `irq` is 1 exactly when `id_now[0]` is 0, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | FIFOs active; permits time-out reporting |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable write data |
| en_rdata | output | 8 | Enable register read value |
| id_rd | input | 1 | Identification register read strobe |
| id_rdata | output | 4 | Identification value captured at the last read |
| id_now | output | 4 | Live identification code |
| irq | output | 1 | Interrupt request |
| line_err | input | 1 | Receiver line error event |
| rx_avail | input | 1 | Receive data available / trigger level reached |
| char_timeout | input | 1 | Character time-out event |
| tx_empty | input | 1 | Transmit holding register empty |
| modem_chg | input | 1 | Modem status change event |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |

## Verification
Two functions can land in the same cycle:
- A source can be set by a new event in the same cycle as its clearing access, for example `line_err` together with `lsr_rd`, or a rising `tx_empty` together with `thr_wr`.
- An identification read can fall in the same cycle as a change in the reported source.

Random stimulus raises strobes and events independently, so these overlaps occur many times. Directed steps force the transmit-empty read-clear while a higher source is pending. In every case the bench model applies set-over-clear, and it takes the snapshot from the code shown before the edge.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int ID_W  = 4;
  localparam int EN_W  = 4;
  localparam int REG_W = 8;

  typedef enum logic [ID_W-1:0] {
    ID_MODEM = 4'b0000,
    ID_NONE  = 4'b0001,
    ID_THRE  = 4'b0010,
    ID_RXDA  = 4'b0100,
    ID_LINE  = 4'b0110,
    ID_TOUT  = 4'b1100
  } id_code_e;

  // enable bit order is fixed by the host view: bit3..bit0
  typedef struct packed {
    logic modem;
    logic line;
    logic thre;
    logic rx;
  } en_t;

  typedef struct packed {
    logic modem;
    logic line;
    logic tout;
    logic thre;
    logic rx;
  } pend_t;
endpackage

// File: rtl/uirq_sticky.sv
module uirq_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= set[i] | (q[i] & ~clr[i]);
    end
  end
endmodule

// File: rtl/uirq_thre.sv
module uirq_thre (
  input  logic clk,
  input  logic rst,
  input  logic tx_empty,
  input  logic arm,
  input  logic clr,
  output logic pend
);
  logic empty_q;
  logic rise;

  assign rise = tx_empty & ~empty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      pend    <= 1'b0;
    end else begin
      empty_q <= tx_empty;
      pend    <= rise | arm | (pend & ~clr);
    end
  end
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
(
  input  pend_t    pend,
  input  en_t      en,
  input  logic     fifo_mode,
  output id_code_e code,
  output logic     irq
);
  always_comb begin
    if      (pend.line  & en.line)              code = ID_LINE;
    else if (pend.rx    & en.rx)                code = ID_RXDA;
    else if (pend.tout  & en.rx & fifo_mode)    code = ID_TOUT;
    else if (pend.thre  & en.thre)              code = ID_THRE;
    else if (pend.modem & en.modem)             code = ID_MODEM;
    else                                        code = ID_NONE;
  end

  assign irq = (pend.line & en.line) | (pend.rx & en.rx) |
               (pend.tout & en.rx & fifo_mode) | (pend.thre & en.thre) |
               (pend.modem & en.modem);
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
  import uirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic             en_wr,
  input  logic [REG_W-1:0] en_wdata,
  output logic [REG_W-1:0] en_rdata,
  input  logic             id_rd,
  output logic [ID_W-1:0]  id_rdata,
  output logic [ID_W-1:0]  id_now,
  output logic             irq,
  input  logic             line_err,
  input  logic             rx_avail,
  input  logic             char_timeout,
  input  logic             tx_empty,
  input  logic             modem_chg,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             rbr_rd,
  input  logic             thr_wr
);
  localparam int NSTICKY = 3;

  logic [EN_W-1:0]    en_q;
  en_t                en;
  logic [NSTICKY-1:0] st_set, st_clr, st_q;
  logic               thre_pend, thre_arm, thre_clr;
  pend_t              pend;
  id_code_e           code;
  logic [ID_W-1:0]    snap_q;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (en_wr) en_q <= en_wdata[EN_W-1:0];
  end

  assign en       = en_t'(en_q);
  assign en_rdata = {{(REG_W-EN_W){1'b0}}, en_q};

  // sticky sources: [0] line, [1] time-out, [2] modem
  assign st_set = {modem_chg, char_timeout, line_err};
  assign st_clr = {msr_rd,    rbr_rd,       lsr_rd};

  uirq_sticky #(.N(NSTICKY)) u_sticky (
    .clk(clk), .rst(rst), .set(st_set), .clr(st_clr), .q(st_q)
  );

  assign thre_arm = en_wr & en_wdata[1] & ~en_q[1] & tx_empty;
  assign thre_clr = thr_wr | (id_rd & (code == ID_THRE));

  uirq_thre u_thre (
    .clk(clk), .rst(rst), .tx_empty(tx_empty),
    .arm(thre_arm), .clr(thre_clr), .pend(thre_pend)
  );

  assign pend.line  = st_q[0];
  assign pend.tout  = st_q[1];
  assign pend.modem = st_q[2];
  assign pend.rx    = rx_avail;
  assign pend.thre  = thre_pend;

  uirq_prio u_prio (
    .pend(pend), .en(en), .fifo_mode(fifo_mode), .code(code), .irq(irq)
  );

  assign id_now = code;

  always_ff @(posedge clk) begin
    if (rst)        snap_q <= ID_NONE;
    else if (id_rd) snap_q <= code;
  end

  assign id_rdata = snap_q;
endmodule

// File: rtl/uirq_ident_chk.sv
module uirq_ident_chk (
  input logic       clk,
  input logic       rst,
  input logic       fifo_mode,
  input logic       en_wr,
  input logic [7:0] en_wdata,
  input logic [7:0] en_rdata,
  input logic       id_rd,
  input logic [3:0] id_rdata,
  input logic [3:0] id_now,
  input logic       irq,
  input logic       line_err,
  input logic       tx_empty,
  input logic       lsr_rd,
  input logic       thr_wr
);
  p_en_load_r2: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> en_rdata == {4'b0000, $past(en_wdata[3:0])});

  p_line_first_r6: assert property (@(posedge clk) disable iff (rst)
    line_err && en_rdata[2] && !en_wr |=> id_now == 4'b0110);

  p_line_clear_r6: assert property (@(posedge clk) disable iff (rst)
    lsr_rd && !line_err |=> id_now != 4'b0110);

  p_no_tout_r4: assert property (@(posedge clk) disable iff (rst)
    !fifo_mode |-> !id_now[3]);

  p_thre_wrclr_r10: assert property (@(posedge clk) disable iff (rst)
    thr_wr && !tx_empty |=> id_now != 4'b0010);

  p_snapshot_r11: assert property (@(posedge clk) disable iff (rst)
    id_rd |=> id_rdata == $past(id_now));

  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    en_rdata[3:0] == 4'b0000 |-> !irq);

  p_irq_code_r12: assert property (@(posedge clk) disable iff (rst)
    irq == !id_now[0]);
endmodule

bind uirq_ident uirq_ident_chk chk (.*);

// File: tb/tb_uirq_ident.sv
module tb_uirq_ident;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_mode = 1'b0, en_wr = 1'b0, id_rd = 1'b0;
  logic [7:0] en_wdata = '0;
  logic [7:0] en_rdata;
  logic [3:0] id_rdata, id_now;
  logic irq;
  logic line_err = 0, rx_avail = 0, char_timeout = 0, tx_empty = 0, modem_chg = 0;
  logic lsr_rd = 0, msr_rd = 0, rbr_rd = 0, thr_wr = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uirq_ident dut (.*);

  // bench model state
  logic [3:0] m_en;
  logic m_line, m_modem, m_to, m_thre, m_txq;
  logic [3:0] m_snap;

  function automatic logic [3:0] exp_code();
    if (m_line & m_en[2])                   return 4'b0110;
    if (rx_avail & m_en[0])                 return 4'b0100;
    if (m_to & m_en[0] & fifo_mode)         return 4'b1100;
    if (m_thre & m_en[1])                   return 4'b0010;
    if (m_modem & m_en[3])                  return 4'b0000;
    return 4'b0001;
  endfunction

  task automatic model_reset();
    m_en = 0; m_line = 0; m_modem = 0; m_to = 0; m_thre = 0; m_txq = 1; m_snap = 4'b0001;
  endtask

  task automatic model_edge();
    logic [3:0] live;
    logic arm, rise;
    live = exp_code();
    arm  = en_wr & en_wdata[1] & ~m_en[1] & tx_empty;
    rise = tx_empty & ~m_txq;
    if (en_wr) m_en = en_wdata[3:0];
    m_line  = line_err     | (m_line  & ~lsr_rd);
    m_modem = modem_chg    | (m_modem & ~msr_rd);
    m_to    = char_timeout | (m_to    & ~rbr_rd);
    m_thre  = rise | arm | (m_thre & ~(thr_wr | (id_rd && live == 4'b0010)));
    m_txq   = tx_empty;
    if (id_rd) m_snap = live;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " id_now (R3)"}, {4'b0, id_now}, {4'b0, exp_code()});
    chk({tag, " irq (R12)"}, {7'b0, irq}, {7'b0, exp_code() != 4'b0001});
    chk({tag, " id_rdata (R11)"}, {4'b0, id_rdata}, {4'b0, m_snap});
    chk({tag, " en_rdata (R2)"}, en_rdata, {4'b0, m_en});
  endtask

  // one clock: inputs already set; model follows the edge; compare mid-cycle
  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    en_wr = 0; id_rd = 0; line_err = 0; char_timeout = 0; modem_chg = 0;
    lsr_rd = 0; msr_rd = 0; rbr_rd = 0; thr_wr = 0;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(negedge clk);
    @(posedge clk); @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 en_rdata", en_rdata, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 id_now", {4'b0, id_now}, 8'h01);
    chk("R1 id_rdata", {4'b0, id_rdata}, 8'h01);

    // R2 upper bits read zero
    en_wr = 1; en_wdata = 8'hFF; step("R2 write");
    idle(); chk("R2 en_rdata", en_rdata, 8'h0F);

    // R3 all sources together, then peel off by priority
    fifo_mode = 1; line_err = 1; rx_avail = 1; char_timeout = 1; modem_chg = 1; tx_empty = 1;
    step("R3 raise");
    idle(); step("R3 hold");
    chk("R3 line first", {4'b0, id_now}, 8'h06);
    lsr_rd = 1; step("R6 clear"); idle();
    chk("R6 rx after line", {4'b0, id_now}, 8'h04);
    rx_avail = 0; step("R8 rx drop");
    chk("R4 tout in fifo", {4'b0, id_now}, 8'h0C);
    fifo_mode = 0; step("R4 non-fifo");
    chk("R4 tout hidden", {4'b0, id_now}, 8'h02);
    fifo_mode = 1; rbr_rd = 1; step("R8 rbr clear"); idle();
    chk("R8 thre next", {4'b0, id_now}, 8'h02);
    id_rd = 1; step("R10 id read"); idle();
    chk("R11 snapshot", {4'b0, id_rdata}, 8'h02);
    chk("R10 thre gone", {4'b0, id_now}, 8'h00);
    msr_rd = 1; step("R7 clear"); idle();
    chk("R7 none", {4'b0, id_now}, 8'h01);

    // R10: read while line shown keeps thre
    tx_empty = 0; step("R9 prep"); tx_empty = 1; line_err = 1; step("R9 rise"); idle();
    id_rd = 1; step("R10 other read"); idle();
    lsr_rd = 1; step("R10 lsr"); idle();
    chk("R10 thre kept", {4'b0, id_now}, 8'h02);

    // R9 arm through enable, R5 masked pending
    en_wr = 1; en_wdata = 8'h00; thr_wr = 1; step("R9 off"); idle();
    line_err = 1; step("R5 masked line"); idle();
    chk("R5 no irq", {7'b0, irq}, 8'h00);
    en_wr = 1; en_wdata = 8'h02; step("R9 arm"); idle();
    chk("R9 armed", {4'b0, id_now}, 8'h02);
    en_wr = 1; en_wdata = 8'h06; step("R5 enable line"); idle();
    chk("R5 line shown", {4'b0, id_now}, 8'h06);
    // R6 set wins over clear
    line_err = 1; lsr_rd = 1; step("R6 set wins"); idle();
    chk("R6 still pending", {4'b0, id_now}, 8'h06);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      en_wr        = ($urandom % 12) == 0;
      en_wdata     = 8'($urandom);
      id_rd        = ($urandom % 6) == 0;
      line_err     = ($urandom % 10) == 0;
      modem_chg    = ($urandom % 10) == 0;
      char_timeout = ($urandom % 10) == 0;
      lsr_rd       = ($urandom % 6) == 0;
      msr_rd       = ($urandom % 6) == 0;
      rbr_rd       = ($urandom % 6) == 0;
      thr_wr       = ($urandom % 6) == 0;
      if (($urandom % 5) == 0)  rx_avail  = ~rx_avail;
      if (($urandom % 4) == 0)  tx_empty  = ~tx_empty;
      if (($urandom % 40) == 0) fifo_mode = ~fifo_mode;
      step("R3 random");
    end
    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule